// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block takes an asynchronous DRAM from reset to a usable state and then keeps its contents alive. After reset it waits out a fixed dwell time, then runs a short burst of dummy refresh cycles. Once that burst is done it raises a ready flag for the access engine. From then on an interval timer marks one refresh as owed at a fixed average rate. Every refresh is a CAS-before-RAS cycle: both byte column strobes fall first, then the row strobe, then all strobes precharge high together.

The block shares the strobes with an access engine through a plain request/grant handshake. While a refresh is owed and no refresh cycle is running, the block raises `ref_req`. The engine answers with `ref_gnt` once it has finished its current access and parked the bus. The block owns the strobes for as long as `ref_req` stays high. While the engine keeps `ref_gnt` high, owed refreshes run back to back without `ref_req` dropping. When `ref_req` falls, the bus goes back to the engine. A small saturating counter holds refreshes that are postponed by long access bursts. When more refreshes come due than the counter can hold, the extra ones are dropped.

Every timing value is a parameter counted in clock cycles. The row-low time is the larger of the RAS pulse width and the CAS hold after RAS. The precharge time is the largest of the RAS precharge, the CAS-high time before a new refresh, and whatever the minimum cycle time still needs.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `lcas_n` and `ucas_n` are 1, and `ref_req` and `mem_ready` are 0.
- R2: For the first PWRUP_CYC clock edges after reset is released, no strobe goes low and `ref_req` stays 0, whatever `ref_gnt` does.
- R3: After the power-up dwell, exactly INIT_REFS refresh cycles run before `mem_ready` rises. `mem_ready` rises on the edge that ends the last of these cycles' precharge, and it then stays 1 until reset.
- R4: In every refresh, both CAS strobes are low for exactly CSR_CYC cycles before `ras_n` falls. They stay low for the whole time `ras_n` is low, and they rise on the same edge as `ras_n`.
- R5: `ras_n` stays low for max(RAS_CYC, CHR_CYC) cycles. All strobes then stay high for max(RP_CYC, RPC_CYC, RC_CYC - rowlow - CSR_CYC) cycles before another refresh may begin.
- R6: `lcas_n` and `ucas_n` are equal on every cycle.
- R7: Once `mem_ready` is 1, one refresh becomes owed every INTERVAL_CYC cycles.
- R8: `ref_req` is 1 while the block is idle and a refresh is owed, and on every cycle of a refresh cycle. A refresh starts on the clock edge that samples `ref_gnt` high while `ref_req` is high. No strobe is low while `ref_req` is 0.
- R9: At most MAX_PEND owed refreshes are held, and the rest are dropped. When a precharge ends with a refresh still owed and `ref_gnt` high, the next refresh's CAS phase begins on that edge and `ref_req` does not drop.
- R10: `ref_gnt` has no effect while `ref_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access engine hands the strobes to the sequencer |
| ref_req | output | 1 | Sequencer asks for, or holds, the strobes |
| mem_ready | output | 1 | Initialization finished; normal accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |

## Verification
The bench builds the block with a 30-cycle power-up dwell, a 60-cycle refresh interval and a 4-entry pending limit. It uses strobe times of 2, 5, 2, 3, 1 and 12 cycles, which stretch the precharge to 5 cycles through the cycle-time term. The short dwell and interval let the whole life of the block fit in about 1200 cycles: the dwell, the init burst, steady refresh, and a 360-cycle grant blackout. The blackout owes six refreshes, so the pending counter saturates, and the resumed burst shows refreshes running back to back under a continuous request.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_CSR,
    ST_RAS,
    ST_PRE
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R7: ticks are INTERVAL_CYC apart, never on adjacent cycles
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic owe,
  input  logic pay,
  output logic nonzero
);
  localparam int DW = $clog2(MAX_PEND + 1);
  localparam logic [DW-1:0] CAP = DW'(MAX_PEND);

  logic [DW-1:0] debt;

  assign nonzero = (debt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) debt <= '0;
    else if (owe && !pay) begin
      if (debt != CAP) debt <= debt + 1'b1;
    end else if (pay && !owe) begin
      debt <= debt - 1'b1;
    end
  end

  // R9: held debt never exceeds the limit
  assert_debt_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= CAP);
  // R9: a refresh is only taken while one is owed
  assert_pay_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pay |-> nonzero);
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
  import refresh_pkg::*;
#(
  parameter int PWRUP_CYC = 20000,
  parameter int INIT_REFS = 8,
  parameter int CSR_CYC   = 1,
  parameter int ROW_LOW   = 7,
  parameter int PRE_LEN   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  input  logic debt_nz,
  output logic req,
  output logic take_debt,
  output logic ready,
  output logic ras_n,
  output logic cas_n
);
  localparam int CW = $clog2(imax(imax(PWRUP_CYC, CSR_CYC), imax(ROW_LOW, PRE_LEN)) + 1);
  localparam int IW = $clog2(INIT_REFS + 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] init_left;
  logic          owed;
  logic          start;
  logic          cnt_done;

  assign cnt_done = (cnt == '0);
  assign owed     = (init_left != '0) || debt_nz;

  always_comb begin
    start = 1'b0;
    if (state == ST_IDLE) start = owed && gnt;
    else if (state == ST_PRE) start = cnt_done && owed && gnt;
  end

  assign take_debt = start && (init_left == '0);
  assign req   = (state == ST_CSR) || (state == ST_RAS) || (state == ST_PRE) ||
                 ((state == ST_IDLE) && owed);
  assign ras_n = (state != ST_RAS);
  assign cas_n = !((state == ST_CSR) || (state == ST_RAS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PWR;
      cnt       <= CW'(PWRUP_CYC - 1);
      init_left <= IW'(INIT_REFS);
      ready     <= 1'b0;
    end else begin
      case (state)
        ST_PWR: begin
          if (cnt_done) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_CSR: begin
          if (cnt_done) begin
            state <= ST_RAS;
            cnt   <= CW'(ROW_LOW - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_RAS: begin
          if (cnt_done) begin
            state <= ST_PRE;
            cnt   <= CW'(PRE_LEN - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_PRE: begin
          if (cnt_done) begin
            if (init_left == '0) ready <= 1'b1;
            if (!start) state <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
      if (start) begin
        state <= ST_CSR;
        cnt   <= CW'(CSR_CYC - 1);
        if (init_left != '0) init_left <= init_left - 1'b1;
      end
    end
  end

  // R4: the column strobes were already low when the row strobe falls
  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  // R4: column strobes held low for the whole row-low time
  assert_cas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  // R8: strobes only move while the bus is requested
  assert_strobe_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> req);
  // R3: ready never falls once set
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R3: ready rises with all strobes parked high
  assert_ready_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (ras_n && cas_n));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import refresh_pkg::*;
#(
  parameter int PWRUP_CYC    = 20000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 8,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 7,
  parameter int CHR_CYC      = 2,
  parameter int RP_CYC       = 5,
  parameter int RPC_CYC      = 1,
  parameter int RC_CYC       = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic mem_ready,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n
);
  localparam int ROW_LOW = imax(RAS_CYC, CHR_CYC);
  localparam int PRE_LEN = imax(imax(RP_CYC, RPC_CYC), RC_CYC - ROW_LOW - CSR_CYC);

  logic tick;
  logic debt_nz;
  logic take_debt;
  logic cas_n;

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(mem_ready), .tick(tick)
  );

  refresh_debt_counter #(.MAX_PEND(MAX_PEND)) u_debt (
    .clk(clk), .rst_n(rst_n), .owe(tick), .pay(take_debt), .nonzero(debt_nz)
  );

  cbr_strobe_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .INIT_REFS(INIT_REFS), .CSR_CYC(CSR_CYC),
    .ROW_LOW(ROW_LOW), .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .gnt(ref_gnt), .debt_nz(debt_nz),
    .req(ref_req), .take_debt(take_debt), .ready(mem_ready),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  assign lcas_n = cas_n;
  assign ucas_n = cas_n;
endmodule

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
  localparam int PWR = 30, INIT = 8, INTV = 60, MAXP = 4;
  localparam int CSR = 2, RAS = 5, CHR = 2, RP = 3, RPC = 1, RC = 12;
  localparam int ROWL = (RAS > CHR) ? RAS : CHR;
  localparam int PREL = 5; // max(3,1,12-5-2)

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, mem_ready, ras_n, lcas_n, ucas_n;
  int checks = 0, fails = 0, mode = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYC(PWR), .INIT_REFS(INIT), .INTERVAL_CYC(INTV), .MAX_PEND(MAXP),
    .CSR_CYC(CSR), .RAS_CYC(RAS), .CHR_CYC(CHR), .RP_CYC(RP), .RPC_CYC(RPC), .RC_CYC(RC)
  ) u0 (.clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .mem_ready(mem_ready), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model: phase 0 dwell, 1 idle, 2 cas-only, 3 row low, 4 precharge
  int ph, rem, ileft, pend, tim;
  bit rdy;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; rem = PWR - 1; ileft = INIT; pend = 0; tim = 0; rdy = 0;
    end else begin
      automatic bit owed = (ileft > 0) || (pend > 0);
      automatic bit tk = rdy && (tim == INTV - 1);
      automatic bit go = 0, use_pend = 0, set_rdy = 0;
      if (ph == 0) begin if (rem == 0) ph = 1; else rem--; end
      else if (ph == 1) go = owed && ref_gnt;
      else if (ph == 2) begin if (rem == 0) begin ph = 3; rem = ROWL - 1; end else rem--; end
      else if (ph == 3) begin if (rem == 0) begin ph = 4; rem = PREL - 1; end else rem--; end
      else begin
        if (rem == 0) begin
          if (ileft == 0) set_rdy = 1;
          if (owed && ref_gnt) go = 1; else ph = 1;
        end else rem--;
      end
      if (go) begin
        ph = 2; rem = CSR - 1;
        if (ileft > 0) ileft--; else use_pend = 1;
      end
      if (rdy) tim = (tim == INTV - 1) ? 0 : tim + 1; else tim = 0;
      if (tk && !use_pend) pend = (pend < MAXP) ? pend + 1 : MAXP;
      else if (use_pend && !tk) pend--;
      if (set_rdy) rdy = 1;
    end
  end

  // engine model and per-cycle comparison
  bit prev_ras = 1, prev_rdy = 0, in_burst = 0, burst_armed = 0;
  int falls_before_ready = 0, pwr_activity = 0, since_rel = 0, cas_run = 0, row_run = 0, burst = 0;
  always @(negedge clk) begin
    cyc++;
    if (mode == 0) ref_gnt <= 1'b1;
    else if (mode == 1) ref_gnt <= ref_req;
    else ref_gnt <= 1'b0;
    if (rst_n) begin
      automatic bit m_ras = (ph != 3);
      automatic bit m_cas = !(ph == 2 || ph == 3);
      automatic bit m_req = (ph >= 2) || (ph == 1 && (ileft > 0 || pend > 0));
      since_rel++;
      if (since_rel < PWR && (!ras_n || !lcas_n || ref_req)) pwr_activity++;
      chk(ras_n == m_ras, "R5 ras_n", ras_n, m_ras);
      chk(lcas_n == m_cas, "R4 cas", lcas_n, m_cas);
      chk(lcas_n == ucas_n, "R6 byte strobes", ucas_n, lcas_n);
      chk(ref_req == m_req, "R7/R8 ref_req", ref_req, m_req);
      chk(mem_ready == rdy, "R3 mem_ready", mem_ready, rdy);
      if (!lcas_n && ras_n) cas_run++;
      if (!ras_n) row_run++;
      if (prev_ras && !ras_n) begin
        chk(cas_run == CSR, "R4 cas lead", cas_run, CSR);
        if (!mem_ready) falls_before_ready++;
        if (in_burst) burst++;
      end
      if (!prev_ras && ras_n) begin
        chk(row_run == ROWL, "R5 row low", row_run, ROWL);
        chk(lcas_n == 1'b1, "R4 cas rises with ras", lcas_n, 1);
        row_run = 0;
      end
      if (ras_n && lcas_n) cas_run = 0;
      if (!prev_rdy && mem_ready)
        chk(falls_before_ready == INIT, "R3 init refreshes", falls_before_ready, INIT);
      if (burst_armed && ref_req) begin in_burst = 1; burst_armed = 0; end
      if (in_burst && !ref_req) begin
        chk(burst >= MAXP && burst <= MAXP + 1, "R9 saturated burst", burst, MAXP);
        in_burst = 0;
      end
      prev_ras = ras_n; prev_rdy = mem_ready;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(ras_n && lcas_n && ucas_n, "R1 strobes in reset", {ras_n, lcas_n, ucas_n}, 7);
    chk(!ref_req && !mem_ready, "R1 req/ready in reset", {ref_req, mem_ready}, 0);
    @(negedge clk); rst_n = 1;
    repeat (PWR + 2) @(negedge clk);
    chk(pwr_activity == 0, "R2 R10 quiet dwell with grant high", pwr_activity, 0);
    repeat (120) @(negedge clk);
    chk(mem_ready == 1'b1, "R3 ready after init", mem_ready, 1);
    mode = 1;
    repeat (400) @(negedge clk);
    mode = 2;
    repeat (360) @(negedge clk);
    mode = 1; burst_armed = 1;
    repeat (300) @(negedge clk);
    chk(burst >= MAXP, "R9 burst seen", burst, MAXP);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); chk(0, "watchdog", 0, 1); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule